// File: doc/BRIEF.md
# Multi-function 32-bit Integer ALU

This block is the combinational arithmetic and logic unit of a simple load/store processor datapath. It takes two operands and a 4-bit operation code. It returns a result word and a flag that is high when every bit of the result is zero. It supports bitwise AND, OR and NOR, addition, subtraction, and signed set-on-less-than. Branch-on-equal logic uses the flag after a subtraction to decide whether the two operands match.

The datapath is a chain of identical one-bit slices in ripple-carry order. Each slice has an optional inversion on each input and a four-way output selector. The two top bits of the operation code drive the inversions: bit 3 inverts operand a and bit 2 inverts operand b. When b is inverted, the same bit also becomes the carry into bit 0, so subtraction needs no second adder. The low two bits of the code choose the slice output. Codes outside the defined set give a zero result. The block has no clock and no state.

Top module: `int_alu`

## Requirements
- R1: Code 4'b0000 gives result = a AND b.
- R2: Code 4'b0001 gives result = a OR b.
- R3: Code 4'b0010 gives result = (a + b) modulo 2^32, and the carry out of bit 31 is discarded.
- R4: Code 4'b0110 gives result = (a - b) modulo 2^32, computed as a + ~b + 1.
- R5: Code 4'b0111 gives result bit 0 = 1 when a < b as signed two's-complement values and 0 otherwise; result bits 31..1 are 0.
- R6: The set-on-less-than comparison is correct when a - b overflows (for example a = 0x80000000, b = 1 gives 1; a = 0x7FFFFFFF, b = 0xFFFFFFFF gives 0).
- R7: Code 4'b1100 gives result = NOT (a OR b), formed as (NOT a) AND (NOT b).
- R8: The zero output is 1 exactly when all 32 result bits are 0.
- R9: Every code other than 0000, 0001, 0010, 0110, 0111 and 1100 gives a result of 0, so zero reads 1.
- R10: With code 4'b0110, zero is 1 exactly when a equals b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| op_code | input | 4 | Operation select: bit 3 inverts a, bit 2 inverts b, bits 1..0 select the slice output |
| result | output | 32 | Result word |
| zero | output | 1 | High when result is all zeros |

## Verification
Immediate assertions are evaluated whenever the inputs change. They compare the ripple chain's result against a behavioural reference for every defined code, including the signed comparison and the equality flag. They also check that undefined codes produce zero. The overflow corners of set-on-less-than and the carry wrap at 0xFFFFFFFF + 1 hold only if the bench drives those exact operand pairs, so the vector table includes them. The bench also sweeps all sixteen codes to confirm which ones fall back to zero.

// File: rtl/int_alu_pkg.sv
// Package: shared widths, operation codes and slice output selector.
// Assumes: codes follow {invert_a, invert_b, select[1:0]}.
package int_alu_pkg;
    localparam int unsigned OP_W = 4;

    localparam logic [OP_W-1:0] OPC_AND = 4'b0000;
    localparam logic [OP_W-1:0] OPC_OR  = 4'b0001;
    localparam logic [OP_W-1:0] OPC_ADD = 4'b0010;
    localparam logic [OP_W-1:0] OPC_SUB = 4'b0110;
    localparam logic [OP_W-1:0] OPC_SLT = 4'b0111;
    localparam logic [OP_W-1:0] OPC_NOR = 4'b1100;

    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } slice_sel_e;
endpackage

// File: rtl/int_alu_decode.sv
// Module: int_alu_decode
// Splits the operation code into input inversions and an output selector,
// and flags codes outside the defined set.
// Assumes: purely combinational; the caller zeroes the result when invalid.
module int_alu_decode
    import int_alu_pkg::*;
(
    input  logic [OP_W-1:0] op_code,
    output logic            inv_a,
    output logic            inv_b,
    output slice_sel_e      sel,
    output logic            op_valid
);
    // Field split: top bits invert, low bits select.
    always_comb begin
        inv_a = op_code[3];
        inv_b = op_code[2];
        sel   = slice_sel_e'(op_code[1:0]);
    end

    // Membership test against the supported codes.
    always_comb begin
        unique case (op_code)
            OPC_AND, OPC_OR, OPC_ADD, OPC_SUB, OPC_SLT, OPC_NOR: op_valid = 1'b1;
            default:                                             op_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/int_alu_slice.sv
// Module: int_alu_slice
// One bit of the ALU: optional input inversion, AND, OR, full add,
// and a four-way selector that can also pass an external less bit.
// Assumes: the less input is the comparison bit for slice 0 and 0 elsewhere.
module int_alu_slice
    import int_alu_pkg::*;
(
    input  logic       a_bit,
    input  logic       b_bit,
    input  logic       inv_a,
    input  logic       inv_b,
    input  logic       carry_in,
    input  logic       less_in,
    input  slice_sel_e sel,
    output logic       sum_bit,
    output logic       carry_out,
    output logic       res_bit
);
    logic a_eff;
    logic b_eff;

    // Conditional inversion of each operand bit.
    always_comb begin
        a_eff = a_bit ^ inv_a;
        b_eff = b_bit ^ inv_b;
    end

    // Full adder: majority for carry, parity for sum.
    always_comb begin
        sum_bit   = a_eff ^ b_eff ^ carry_in;
        carry_out = (a_eff & b_eff) | (a_eff & carry_in) | (b_eff & carry_in);
    end

    // Output selector.
    always_comb begin
        unique case (sel)
            SEL_AND:  res_bit = a_eff & b_eff;
            SEL_OR:   res_bit = a_eff | b_eff;
            SEL_SUM:  res_bit = sum_bit;
            SEL_LESS: res_bit = less_in;
            default:  res_bit = 1'b0;
        endcase
    end
endmodule

// File: rtl/int_alu_less.sv
// Module: int_alu_less
// Forms the signed less-than bit from the top slice of a subtraction.
// Assumes: msb_sum, msb_cin and msb_cout come from the most significant slice.
module int_alu_less (
    input  logic msb_sum,
    input  logic msb_cin,
    input  logic msb_cout,
    output logic less
);
    logic ovf;

    // Signed overflow, then sign corrected for it.
    always_comb begin
        ovf  = msb_cin ^ msb_cout;
        less = msb_sum ^ ovf;
    end
endmodule

// File: rtl/int_alu.sv
// Module: int_alu (top)
// Ripple chain of WIDTH one-bit slices plus decode, comparison and zero flag.
// Assumes: no clock; outputs settle combinationally from the inputs.
module int_alu
    import int_alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [OP_W-1:0]  op_code,
    output logic [WIDTH-1:0] result,
    output logic             zero
);
    localparam int unsigned MSB = WIDTH - 1;

    logic             inv_a;
    logic             inv_b;
    slice_sel_e       sel;
    logic             op_valid;
    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] sum_w;
    logic [WIDTH-1:0] chain_res;
    logic             less;

    int_alu_decode u_decode (
        .op_code  (op_code),
        .inv_a    (inv_a),
        .inv_b    (inv_b),
        .sel      (sel),
        .op_valid (op_valid)
    );

    // Carry into bit 0 is the b-invert bit, which completes two's complement.
    always_comb carry[0] = inv_b;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        logic less_i;
        if (i == 0) begin : g_lsb
            always_comb less_i = less;
        end else begin : g_upper
            always_comb less_i = 1'b0;
        end
        int_alu_slice u_slice (
            .a_bit     (opa[i]),
            .b_bit     (opb[i]),
            .inv_a     (inv_a),
            .inv_b     (inv_b),
            .carry_in  (carry[i]),
            .less_in   (less_i),
            .sel       (sel),
            .sum_bit   (sum_w[i]),
            .carry_out (carry[i+1]),
            .res_bit   (chain_res[i])
        );
    end

    int_alu_less u_less (
        .msb_sum  (sum_w[MSB]),
        .msb_cin  (carry[MSB]),
        .msb_cout (carry[WIDTH]),
        .less     (less)
    );

    // Undefined codes force zero; flag tracks an all-zero result.
    always_comb begin
        result = op_valid ? chain_res : '0;
        zero   = ~|result;
    end

    // Behavioural cross-checks of the slice chain.
    always_comb begin
        if (op_code == OPC_AND)
            p_and_r1: assert (result == (opa & opb));
        if (op_code == OPC_OR)
            p_or_r2: assert (result == (opa | opb));
        if (op_code == OPC_ADD)
            p_add_wrap_r3: assert (result == WIDTH'(opa + opb));
        if (inv_b && !inv_a)
            p_sub_sum_r4: assert (sum_w == WIDTH'(opa - opb));
        if (op_code == OPC_SLT)
            p_slt_signed_r5_r6: assert (result == WIDTH'($signed(opa) < $signed(opb)));
        if (op_code == OPC_NOR)
            p_nor_r7: assert (result == ~(opa | opb));
        p_zero_flag_r8: assert (zero == (chain_res == '0 || !op_valid));
        if (!(op_code inside {OPC_AND, OPC_OR, OPC_ADD, OPC_SUB, OPC_SLT, OPC_NOR}))
            p_undef_zero_r9: assert (result == '0 && zero);
        if (op_code == OPC_SUB)
            p_eq_flag_r10: assert (zero == (opa == opb));
    end
endmodule

// File: tb/int_alu_test.sv
module int_alu_test;
    localparam int W = 32;
    localparam int NV = 14;

    typedef struct packed {
        logic [3:0]   op;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] r;
        logic         z;
    } vec_t;

    // Stimulus and expected results.
    localparam vec_t VECS [NV] = '{
        '{4'b0000, 32'hF0F0_1234, 32'h0FF0_FF00, 32'h00F0_1200, 1'b0}, // R1
        '{4'b0001, 32'hF000_0001, 32'h000F_0010, 32'hF00F_0011, 1'b0}, // R2
        '{4'b0010, 32'h0000_0005, 32'h0000_0007, 32'h0000_000C, 1'b0}, // R3
        '{4'b0010, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b1}, // R3 wrap
        '{4'b0110, 32'h0000_000A, 32'h0000_0003, 32'h0000_0007, 1'b0}, // R4
        '{4'b0110, 32'h0000_0003, 32'h0000_000A, 32'hFFFF_FFF9, 1'b0}, // R4 negative
        '{4'b0110, 32'h1234_5678, 32'h1234_5678, 32'h0000_0000, 1'b1}, // R10
        '{4'b0111, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001, 1'b0}, // R5
        '{4'b0111, 32'h0000_0005, 32'h0000_0003, 32'h0000_0000, 1'b1}, // R5
        '{4'b0111, 32'h8000_0000, 32'h0000_0001, 32'h0000_0001, 1'b0}, // R6
        '{4'b0111, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1}, // R6
        '{4'b1100, 32'hF0F0_0000, 32'h0F00_FFFF, 32'h000F_0000, 1'b0}, // R7
        '{4'b1100, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0}, // R7
        '{4'b0111, 32'hFFFF_FFFB, 32'hFFFF_FFFB, 32'h0000_0000, 1'b1}  // R5 equal
    };
    localparam string TAGS [NV] = '{"R1", "R2", "R3", "R3", "R4", "R4", "R10",
                                    "R5", "R5", "R6", "R6", "R7", "R7", "R5"};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic [3:0]   op_code = '0;
    logic [W-1:0] result;
    logic         zero;
    int           n_run = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    int_alu #(.WIDTH(W)) uut (
        .opa     (opa),
        .opb     (opb),
        .op_code (op_code),
        .result  (result),
        .zero    (zero)
    );

    always #4 clk = ~clk; // 125 MHz

    task automatic apply(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        @(posedge clk);
        op_code = op;
        opa     = a;
        opb     = b;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [W-1:0] exp_r, input logic exp_z);
        n_run++;
        if (result !== exp_r || zero !== exp_z) begin
            n_fail++;
            $display("FAIL %s op=%b a=%h b=%h: result=%h zero=%b expected result=%h zero=%b",
                     req, op_code, opa, opb, result, zero, exp_r, exp_z);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        // Initial state under reset: AND of zeros reads zero with flag set (R1, R8).
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8", '0, 1'b1);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].op, VECS[i].a, VECS[i].b);
            check(TAGS[i], VECS[i].r, VECS[i].z);
        end

        // Undefined codes give zero (R9).
        for (int c = 0; c < 16; c++) begin
            if (!(c inside {0, 1, 2, 6, 7, 12})) begin
                apply(4'(c), 32'hFFFF_FFFF, 32'h1234_5678);
                check("R9", '0, 1'b1);
            end
        end

        // Equality flag on unequal operands differing only in the top bit (R10).
        apply(4'b0110, 32'h8000_0000, 32'h0000_0000);
        check("R10", 32'h8000_0000, 1'b0);

        // Most negative is less than most positive (R6).
        apply(4'b0111, 32'h8000_0000, 32'h7FFF_FFFF);
        check("R6", 32'h0000_0001, 1'b0);

        // Full carry ripple across all bits (R3).
        apply(4'b0010, 32'h7FFF_FFFF, 32'h0000_0001);
        check("R3", 32'h8000_0000, 1'b0);

        // NOR of complementary words is zero and sets the flag (R7, R8).
        apply(4'b1100, 32'hAAAA_5555, 32'h5555_AAAA);
        check("R7", 32'h0000_0000, 1'b1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule